// File: doc/BRIEF.md
# Multi-Generator AXI Read Responder

This block answers AXI read bursts from an 8 KB on-chip memory. Accepted read requests wait in a small input queue. A dispatcher hands each one to the lowest-numbered idle burst engine. Each engine walks its burst and produces one word address per beat. There are four engines, and every cycle a round-robin selector lets one of them use the single memory read port. The memory answers one cycle later. The ID and final-beat flag of that read travel in a pipeline register beside it. The result goes into a small response queue, which drives the R channel.

Because up to four bursts are in progress at once, beats from different IDs may interleave on the R channel. Beats within one burst always stay in order. The selector only grants when the response queue can take both the read already in the pipeline and the new one, so backpressure on the R channel never drops a beat. The memory occupies byte offsets 0xC000 to 0xDFFF. Only the offset bits inside that 8 KB window choose a word, so addresses alias and a burst that runs past the top wraps to the bottom. A load port fills the memory on behalf of the write side of the system.

Top module: `axi_rd_engine`

## Requirements
- R1: `s_arready` is high whenever the request queue has room. With `s_rready` held low and default sizes, exactly eight 8-beat bursts are accepted (four in engines, four queued) and `s_arready` then stays low.
- R2: In the cycle after reset is released, `s_rvalid` is low and `s_arready` is high.
- R3: Beat b of a burst returns the memory word at index ((`s_araddr` >> 2) + b) mod 2048. Address bits 13 and up are ignored, and a burst that passes word 2047 continues at word 0.
- R4: A burst with `s_arlen` = L (0 to 15) returns exactly L+1 beats. `s_rlast` is high on the final beat and low on all others.
- R5: Every beat carries in `s_rid` the `s_arid` of the burst it belongs to.
- R6: `s_rresp` is 2'b00 (OKAY) on every beat.
- R7: Up to four bursts are served at the same time. At most one busy engine is granted the memory per cycle, in round-robin order, so beats of different IDs interleave.
- R8: While `s_rvalid` is high and `s_rready` is low, `s_rid`, `s_rdata` and `s_rlast` hold steady. No beat is lost or duplicated under any `s_rready` pattern.
- R9: When `ld_we` is high, `ld_data` is written to the word that `ld_addr` selects under the R3 mapping. Reads issued afterwards return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_arvalid | input | 1 | Read request valid |
| s_arready | output | 1 | Read request accepted |
| s_arid | input | ID_W | Request ID |
| s_araddr | input | ADDR_W | Byte address of first beat (word aligned) |
| s_arlen | input | LEN_W | Beats minus one |
| s_rvalid | output | 1 | Read beat valid |
| s_rready | input | 1 | Read beat accepted |
| s_rid | output | ID_W | ID of this beat |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Response code, always OKAY |
| s_rlast | output | 1 | Final beat of the burst |
| ld_we | input | 1 | Memory load strobe |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_data | input | DATA_W | Word to load |

## Verification
The bench builds the block with its defaults: four engines, 4-deep request and response queues, 32-bit data, 16-bit addresses and up to 16 beats per burst. With these sizes, the R1 limit of eight accepted bursts can be reached with nine requests, and two back-to-back bursts are enough to make IDs interleave. The 2048-word window is small enough to preload completely and to push bursts across its top edge and through aliased upper address bits.

// File: rtl/rd_eng_pkg.sv
package rd_eng_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/rd_sync_fifo.sv
module rd_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rd_agen.sv
module rd_agen #(
  parameter int ID_W  = 4,
  parameter int WA_W  = 11,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ID_W-1:0]  st_id,
  input  logic [WA_W-1:0]  st_widx,
  input  logic [LEN_W-1:0] st_len,
  input  logic             grant,
  output logic             busy,
  output logic [ID_W-1:0]  id,
  output logic [WA_W-1:0]  widx,
  output logic             last
);
  logic [LEN_W-1:0] rem_q;

  assign last = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      id    <= '0;
      widx  <= '0;
      rem_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      id    <= st_id;
      widx  <= st_widx;
      rem_q <= st_len;
    end else if (grant) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        widx  <= widx + 1'b1;
        rem_q <= rem_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rd_rr_sel.sv
module rd_rr_sel #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;

  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (en && (gnt == '0) && req[(int'(last_q) + 1 + i) % N])
        gnt[(int'(last_q) + 1 + i) % N] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IW'(N - 1);
    end else begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) last_q <= IW'(i);
      end
    end
  end
endmodule

// File: rtl/axi_rd_engine.sv
module axi_rd_engine
  import rd_eng_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 8192,
  parameter int NGEN      = 4,
  parameter int AR_DEPTH  = 4,
  parameter int R_DEPTH   = 4,
  parameter int MAX_BEATS = 16,
  parameter int LEN_W     = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data
);
  localparam int BYTE_LSB = $clog2(DATA_W / 8);
  localparam int WORDS    = MEM_BYTES / (DATA_W / 8);
  localparam int WA_W     = $clog2(WORDS);
  localparam int AFW      = ID_W + WA_W + LEN_W;
  localparam int RFW      = ID_W + DATA_W + 1;
  localparam int RCW      = $clog2(R_DEPTH + 1);

  // request queue
  logic [AFW-1:0] af_din, af_dout;
  logic           af_empty, af_full, af_pop;
  logic [$clog2(AR_DEPTH+1)-1:0] af_cnt;

  assign af_din    = {s_arid, s_araddr[BYTE_LSB +: WA_W], s_arlen};
  assign s_arready = !af_full;

  rd_sync_fifo #(.W(AFW), .DEPTH(AR_DEPTH)) i_ar_q (
    .clk(clk), .rst(rst), .push(s_arvalid && s_arready), .din(af_din),
    .pop(af_pop), .dout(af_dout), .empty(af_empty), .full(af_full), .cnt(af_cnt)
  );

  logic [ID_W-1:0]  q_id;
  logic [WA_W-1:0]  q_widx;
  logic [LEN_W-1:0] q_len;
  assign {q_id, q_widx, q_len} = af_dout;

  // dispatcher: lowest idle engine
  logic [NGEN-1:0] gen_busy, gen_last, gen_start, gnt, trk_sel;
  logic            trk_free;
  logic [ID_W-1:0] gen_id   [NGEN];
  logic [WA_W-1:0] gen_widx [NGEN];

  always_comb begin
    trk_sel  = '0;
    trk_free = 1'b0;
    for (int g = 0; g < NGEN; g++) begin
      if (!gen_busy[g] && !trk_free) begin
        trk_sel[g] = 1'b1;
        trk_free   = 1'b1;
      end
    end
  end

  assign af_pop    = !af_empty && trk_free;
  assign gen_start = af_pop ? trk_sel : '0;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    rd_agen #(.ID_W(ID_W), .WA_W(WA_W), .LEN_W(LEN_W)) i_agen (
      .clk(clk), .rst(rst), .start(gen_start[g]),
      .st_id(q_id), .st_widx(q_widx), .st_len(q_len),
      .grant(gnt[g]), .busy(gen_busy[g]), .id(gen_id[g]),
      .widx(gen_widx[g]), .last(gen_last[g])
    );
  end

  // selector with response-queue credit
  logic [RCW-1:0] rf_cnt;
  logic           p_vld, credit_ok;

  assign credit_ok = ({1'b0, rf_cnt} + (RCW+1)'(p_vld)) < (RCW+1)'(R_DEPTH);

  rd_rr_sel #(.N(NGEN)) i_sel (
    .clk(clk), .rst(rst), .en(credit_ok), .req(gen_busy), .gnt(gnt)
  );

  logic            rd_en, rd_last;
  logic [WA_W-1:0] rd_widx;
  logic [ID_W-1:0] rd_id;

  always_comb begin
    rd_en   = |gnt;
    rd_widx = '0;
    rd_id   = '0;
    rd_last = 1'b0;
    for (int g = 0; g < NGEN; g++) begin
      if (gnt[g]) begin
        rd_widx = gen_widx[g];
        rd_id   = gen_id[g];
        rd_last = gen_last[g];
      end
    end
  end

  // memory, one-cycle read
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rd_q;
  logic [ID_W-1:0]   p_id;
  logic              p_last;

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr[BYTE_LSB +: WA_W]] <= ld_data;
    if (rd_en) rd_q <= mem[rd_widx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld  <= 1'b0;
      p_id   <= '0;
      p_last <= 1'b0;
    end else begin
      p_vld  <= rd_en;
      p_id   <= rd_id;
      p_last <= rd_last;
    end
  end

  // response queue
  logic           rf_push, rf_full, rf_empty;
  logic [RFW-1:0] rf_dout;

  assign rf_push = p_vld;

  rd_sync_fifo #(.W(RFW), .DEPTH(R_DEPTH)) i_r_q (
    .clk(clk), .rst(rst), .push(rf_push), .din({p_id, rd_q, p_last}),
    .pop(s_rvalid && s_rready), .dout(rf_dout), .empty(rf_empty),
    .full(rf_full), .cnt(rf_cnt)
  );

  assign s_rvalid = !rf_empty;
  assign {s_rid, s_rdata, s_rlast} = rf_dout;
  assign s_rresp = RESP_OKAY;
endmodule

// File: rtl/rd_eng_chk.sv
module rd_eng_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int NGEN   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [ID_W-1:0]   s_rid,
  input logic [DATA_W-1:0] s_rdata,
  input logic              s_rlast,
  input logic [1:0]        s_rresp,
  input logic [NGEN-1:0]   gnt,
  input logic [NGEN-1:0]   gen_busy,
  input logic              rf_push,
  input logic              rf_full
);
  p_reset_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !s_rvalid);

  p_okay_r6: assert property (@(posedge clk) disable iff (rst)
    s_rvalid |-> (s_rresp == 2'b00));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=>
      (s_rvalid && $stable(s_rid) && $stable(s_rdata) && $stable(s_rlast)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    rf_push |-> !rf_full);

  p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_grant_busy_r7: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~gen_busy) == '0));
endmodule

bind axi_rd_engine rd_eng_chk #(.ID_W(ID_W), .DATA_W(DATA_W), .NGEN(NGEN)) i_chk (
  .clk(clk), .rst(rst), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_rid(s_rid), .s_rdata(s_rdata), .s_rlast(s_rlast), .s_rresp(s_rresp),
  .gnt(gnt), .gen_busy(gen_busy), .rf_push(rf_push), .rf_full(rf_full)
);

// File: tb/test_axi_rd_engine.sv
module test_axi_rd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2048;

  // stimulus table: {id[3:0], byte addr[15:0], len[7:0], pad[3:0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 16'hC000, 8'd0,  4'h0},
    {4'd2, 16'hC010, 8'd3,  4'h0},
    {4'd3, 16'hDFF8, 8'd3,  4'h0},
    {4'd4, 16'h1004, 8'd15, 4'h0},
    {4'd5, 16'hC100, 8'd7,  4'h0},
    {4'd6, 16'hFFFC, 8'd1,  4'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [3:0]  s_arid = '0;
  logic [15:0] s_araddr = '0;
  logic [3:0]  s_arlen = '0;
  logic        s_rvalid;
  logic        s_rready = 1'b0;
  logic [3:0]  s_rid;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rlast;
  logic        ld_we = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [31:0] ld_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_rd_engine i_axi_rd_engine (
    .clk(clk), .rst(rst), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_arid(s_arid), .s_araddr(s_araddr), .s_arlen(s_arlen),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  int tests = 0;
  int fails = 0;
  logic [31:0] model [NW];
  int  exp_w [16];
  int  exp_len [16];
  int  beat [16];
  bit  active [16];
  int  beats_rx = 0;
  int  bursts_done = 0;
  bit  ilv_seen = 1'b0;
  int  rr_mode = 0;  // 0 low, 1 high, 2 pseudo-random

  function automatic logic [31:0] pat(int w);
    return 32'hA5C3_0000 ^ (w * 32'h0001_0101);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // rready driver
  initial begin
    logic [7:0] lfsr = 8'h5B;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      s_rready = (rr_mode == 1) || (rr_mode == 2 && lfsr[0]);
    end
  end

  // response collector
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && s_rvalid && s_rready) begin
        int id;
        int w;
        id = int'(s_rid);
        chk(active[id], "R5", "beat for an unknown id", 32'(id), 32'(id));
        w = (exp_w[id] + beat[id]) % NW;
        chk(s_rdata == model[w], "R3", "beat data", s_rdata, model[w]);
        chk(s_rlast == (beat[id] == exp_len[id]), "R4", "last flag",
            32'(s_rlast), 32'(beat[id] == exp_len[id]));
        chk(s_rresp == 2'b00, "R6", "response code", 32'(s_rresp), 32'd0);
        for (int k = 0; k < 16; k++) begin
          if (k != id && active[k] && beat[k] > 0) ilv_seen = 1'b1;
        end
        beat[id]++;
        beats_rx++;
        if (s_rlast) begin
          active[id] = 1'b0;
          bursts_done++;
        end
      end
    end
  end

  task automatic issue(input int id, input logic [15:0] addr, input int len, output bit ok);
    exp_w[id]   = (int'(addr) >> 2) % NW;
    exp_len[id] = len;
    beat[id]    = 0;
    active[id]  = 1'b1;
    ok = 1'b0;
    @(negedge clk);
    s_arvalid = 1'b1;
    s_arid    = 4'(id);
    s_araddr  = addr;
    s_arlen   = 4'(len);
    for (int t = 0; t < 30 && !ok; t++) begin
      #1;
      if (s_arready) ok = 1'b1;
      @(negedge clk);
    end
    s_arvalid = 1'b0;
    if (!ok) active[id] = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    for (int t = 0; t < 4000 && beats_rx < n; t++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit ok;
    int acc;
    for (int k = 0; k < 16; k++) active[k] = 1'b0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(s_rvalid == 1'b0, "R2", "rvalid after reset", 32'(s_rvalid), 32'd0);
    chk(s_arready == 1'b1, "R2", "arready after reset", 32'(s_arready), 32'd1);

    // fill memory through the load port (R9)
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      ld_we   = 1'b1;
      ld_addr = 16'hC000 + 16'(w * 4);
      ld_data = pat(w);
      model[w] = pat(w);
    end
    @(negedge clk);
    ld_we = 1'b0;

    // table-driven bursts, R channel open: R3 R4 R5 R7
    rr_mode = 1;
    for (int i = 0; i < NV; i++) begin
      issue(int'(VEC[i][31:28]), VEC[i][27:12], int'(VEC[i][11:4]), ok);
      chk(ok, "R1", "request accepted", 32'(ok), 32'd1);
    end
    wait_beats(35);
    chk(beats_rx == 35, "R4", "total beats of table", 32'(beats_rx), 32'd35);
    chk(bursts_done == 6, "R4", "bursts finished", 32'(bursts_done), 32'd6);
    chk(ilv_seen, "R7", "beats of different ids interleaved", 32'(ilv_seen), 32'd1);

    // R channel stalled: R1 capacity, R8 no loss
    rr_mode = 0;
    acc = 0;
    for (int i = 0; i < 9; i++) begin
      issue(i, 16'hC200 + 16'(i * 64), 7, ok);
      if (ok) acc++;
    end
    #1;
    chk(acc == 8, "R1", "bursts accepted while stalled", 32'(acc), 32'd8);
    chk(s_arready == 1'b0, "R1", "arready with queue full", 32'(s_arready), 32'd0);
    chk(s_rvalid == 1'b1, "R8", "rvalid held while stalled", 32'(s_rvalid), 32'd1);
    rr_mode = 1;
    wait_beats(35 + 64);
    chk(beats_rx == 99, "R8", "beats after stall", 32'(beats_rx), 32'd99);
    chk(bursts_done == 14, "R8", "bursts after stall", 32'(bursts_done), 32'd14);

    // toggling rready: R8
    rr_mode = 2;
    issue(9,  16'hDFC0, 15, ok);
    issue(10, 16'h2C20, 5,  ok);
    issue(11, 16'hC004, 0,  ok);
    issue(12, 16'hD000, 10, ok);
    wait_beats(99 + 16 + 6 + 1 + 11);
    chk(beats_rx == 133, "R8", "beats under toggling ready", 32'(beats_rx), 32'd133);
    chk(bursts_done == 18, "R4", "bursts under toggling ready", 32'(bursts_done), 32'd18);

    // load port overwrite then read back: R9
    @(negedge clk);
    ld_we = 1'b1;
    ld_addr = 16'hC48C;
    ld_data = 32'hDEAD_BEEF;
    model[(16'hC48C >> 2) % NW] = 32'hDEAD_BEEF;
    @(negedge clk);
    ld_we = 1'b0;
    rr_mode = 1;
    issue(2, 16'hE48C, 0, ok);
    wait_beats(134);
    chk(beats_rx == 134, "R9", "reloaded word returned", 32'(beats_rx), 32'd134);

    repeat (5) @(negedge clk);
    #1;
    chk(s_rvalid == 1'b0, "R8", "no extra beats", 32'(s_rvalid), 32'd0);
    summary();
  end
endmodule